// File: doc/BRIEF.md
# Shared Two-Function Interrupt Controller

This block joins the interrupt sources of a card carrying two functions onto one shared, active-low interrupt request line. Function 0 gathers four general-purpose I/O interrupt inputs, a UART interrupt input and a test source that the host can force. Function 1 gathers a USB host interrupt input and its own forced test source. Each source passes through an enable bit before it can reach its function's request bit.

Each function has a status register holding a request bit and an acknowledge-mode bit. With acknowledge mode off in both functions, the request bits simply follow the enabled sources, and host writes to them are ignored. With acknowledge mode on in either function, a host write of zero to either request bit ends a service cycle. If any enabled source is still pending at that moment, both request bits are cleared. The shared line is then released for a programmable number of clocks and asserted again, so that the host sees a fresh edge.

A separate active-high fast USB output follows the enabled USB source directly and is not affected by the handshake. A small local register port carries host reads and writes.

Top module: `shared_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `irq_n` is 1 and `usb_fast_irq` is 0.
- R2: The register offsets are: 0x10 function 0 status, 0x11 function 1 status, 0x12 test (bits 1:0), 0x13 I/O enable (bits 3:0), 0x14 USB enable (bit 0 standard, bit 1 fast) and 0x15 UART enable (bit 0). A read returns the implemented bits last written, and the unimplemented bits read 0. A status read returns the acknowledge-mode bit in bit 0 and the live request bit in bit 1.
- R3: The function 0 request bit is set one clock after any `io_irq[i]` with enable bit i set, or `uart_irq` with its enable set, or test bit 0 is present. It clears one clock after none of these is present.
- R4: The function 1 request bit is set one clock after `usb_irq` is present with USB enable bit 0 set, or after test bit 1 is set.
- R5: `irq_n` is 0 while either request bit is 1 and 1 otherwise.
- R6: `usb_fast_irq` equals `usb_irq` AND USB enable bit 1, with no clock delay, regardless of the handshake state.
- R7: While the acknowledge-mode bit is 0 in both status registers (before the write), a write to either status register leaves the request bits and `irq_n` unchanged.
- R8: With acknowledge mode on in either function, a write with bit 1 equal to 0 to either status register clears both request bits when a source is pending. `irq_n` is then 1 for exactly GAP_CLKS clocks (default 4) and goes back to 0 after that, with the request bits set again.
- R9: Such an acknowledge write made while no source is pending starts no release window. A source that arrives on the next clock asserts `irq_n` with the normal one-clock latency.
- R10: A forced test source stays pending until the host writes 0 to its test bit.
- R11: A status write with bit 1 equal to 1 does not release the line, even under acknowledge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_irq | input | NUM_IO (4) | General-purpose I/O interrupt inputs, function 0 |
| uart_irq | input | 1 | UART interrupt input, function 0 |
| usb_irq | input | 1 | USB host interrupt input, function 1 |
| reg_addr | input | ADDR_W (5) | Local register offset |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Shared interrupt request, active low |
| usb_fast_irq | output | 1 | Fast USB interrupt, active high |

## Verification
A vector table applies source and enable combinations: a single enabled I/O bit, a masked I/O bit, the UART with and without its enable, and the USB input under each of its two enables. These patterns separate the per-bit masking of the I/O inputs from the function-level OR, and separate the standard USB path from the fast USB path. Directed sequences then compare a status write made with acknowledge mode off against one made with it on, and measure the length of the release window. They also contrast an acknowledge made while a source is pending with one made while nothing is pending, which tells a correct re-notification apart from a window that is always or never started. The persistence of the test sources and the writes of 1 to a request bit are tested separately.

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl #(
  parameter int NUM_IO   = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int GAP_CLKS = 4,
  localparam int CNT_W   = $clog2(GAP_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IO-1:0] io_irq,
  input  logic              uart_irq,
  input  logic              usb_irq,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n,
  output logic              usb_fast_irq
);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_ST1  = ADDR_W'(8'h11);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(8'h12);
  localparam logic [ADDR_W-1:0] A_IOEN = ADDR_W'(8'h13);
  localparam logic [ADDR_W-1:0] A_USBE = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_UREN = ADDR_W'(8'h15);

  logic [NUM_IO-1:0] io_en;
  logic              uart_en;
  logic [1:0]        usb_en, test_q, ackm, req_q;
  logic [CNT_W-1:0]  gap_cnt, gap_nxt;
  logic [1:0]        req_nxt;

  wire src0    = |(io_irq & io_en) | (uart_irq & uart_en) | test_q[0];
  wire src1    = (usb_irq & usb_en[0]) | test_q[1];
  wire stat_wr = reg_wr && (reg_addr == A_ST0 || reg_addr == A_ST1);
  wire ack_wr  = stat_wr && (|ackm) && !reg_wdata[1];

  assign usb_fast_irq = usb_irq & usb_en[1];

  always_comb begin
    if (ack_wr && (src0 || src1)) gap_nxt = CNT_W'(GAP_CLKS);
    else if (gap_cnt != '0)       gap_nxt = gap_cnt - CNT_W'(1);
    else                          gap_nxt = '0;
    req_nxt = (gap_nxt == '0) ? {src1, src0} : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en   <= '0;
      uart_en <= 1'b0;
      usb_en  <= '0;
      test_q  <= '0;
      ackm    <= '0;
      req_q   <= '0;
      gap_cnt <= '0;
      irq_n   <= 1'b1;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_ST0:   ackm[0] <= reg_wdata[0];
          A_ST1:   ackm[1] <= reg_wdata[0];
          A_TEST:  test_q  <= reg_wdata[1:0];
          A_IOEN:  io_en   <= reg_wdata[NUM_IO-1:0];
          A_USBE:  usb_en  <= reg_wdata[1:0];
          A_UREN:  uart_en <= reg_wdata[0];
          default: ;
        endcase
      end
      gap_cnt <= gap_nxt;
      req_q   <= req_nxt;
      irq_n   <= ~|req_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ST0:   reg_rdata = DATA_W'({req_q[0], ackm[0]});
      A_ST1:   reg_rdata = DATA_W'({req_q[1], ackm[1]});
      A_TEST:  reg_rdata = DATA_W'(test_q);
      A_IOEN:  reg_rdata = DATA_W'(io_en);
      A_USBE:  reg_rdata = DATA_W'(usb_en);
      A_UREN:  reg_rdata = DATA_W'(uart_en);
      default: reg_rdata = '0;
    endcase
  end

  assert_req0_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[0] |-> $past(src0));
  assert_req1_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[1] |-> $past(src1));
  assert_gap_holds_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |-> irq_n);
  assert_renotify_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (src0 || src1)) |=> (irq_n && req_q == 2'b00));
  assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= CNT_W'(GAP_CLKS));
  assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ackm == 2'b00 && gap_cnt == '0) |=> gap_cnt == '0);
  assert_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !src0 && !src1 && gap_cnt == '0) |=> gap_cnt == '0);
endmodule

// File: tb/tb_shared_irq_ctrl.sv
`timescale 1ns/1ps
module tb_shared_irq_ctrl;
  localparam int GAP = 4;
  logic clk = 0, rst_n = 0;
  logic [3:0] io_irq = 0;
  logic uart_irq = 0, usb_irq = 0, reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_n, usb_fast_irq;
  int checks = 0, fails = 0;

  shared_irq_ctrl #(.GAP_CLKS(GAP)) dut (.*);

  always #10 clk = ~clk;

  // {gpio[4], uart, usb, io_en[4], uart_en, usb_en[2], req0, req1, fast}
  localparam logic [15:0] VEC [10] = '{
    16'b0000_0_0_1111_1_11_0_0_0,
    16'b0001_0_0_0001_0_00_1_0_0,
    16'b0100_0_0_1011_0_00_0_0_0,
    16'b1000_0_0_1000_0_00_1_0_0,
    16'b0000_1_0_0000_1_00_1_0_0,
    16'b0000_1_0_1111_0_00_0_0_0,
    16'b0000_0_1_0000_0_01_0_1_0,
    16'b0000_0_1_0000_0_10_0_0_1,
    16'b0010_0_1_0010_0_11_1_1_1,
    16'b1111_1_1_0000_0_00_0_0_0
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_req(input string tag, input bit e0, input bit e1);
    logic [7:0] d;
    rd(5'h10, d); chk(d[1] == e0, {tag, " req0"}, d[1], e0);
    rd(5'h11, d); chk(d[1] == e1, {tag, " req1"}, d[1], e1);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_n == 1, "R1 irq_n", irq_n, 1);
    chk(usb_fast_irq == 0, "R1 fast", usb_fast_irq, 0);
    for (int a = 16; a <= 21; a++) begin
      rd(5'(a), d); chk(d == 0, "R1 reg reset", d, 0);
    end
    // R2 read-back
    wr(5'h13, 8'h0A); rd(5'h13, d); chk(d == 8'h0A, "R2 io_en", d, 8'h0A);
    wr(5'h14, 8'h03); rd(5'h14, d); chk(d == 8'h03, "R2 usb_en", d, 3);
    wr(5'h15, 8'hFF); rd(5'h15, d); chk(d == 8'h01, "R2 uart_en", d, 1);

    // R3 R4 R5 R6 vector table
    foreach (VEC[i]) begin
      logic [15:0] v;
      v = VEC[i];
      wr(5'h13, {4'b0, v[9:6]});
      wr(5'h15, {7'b0, v[5]});
      wr(5'h14, {6'b0, v[4:3]});
      io_irq = v[15:12]; uart_irq = v[11]; usb_irq = v[10];
      @(negedge clk);
      chk_req("R3 R4 vector", v[2], v[1]);
      chk(irq_n == !(v[2] | v[1]), "R5 vector irq_n", irq_n, !(v[2] | v[1]));
      chk(usb_fast_irq == v[0], "R6 vector fast", usb_fast_irq, v[0]);
    end
    io_irq = 0; uart_irq = 0; usb_irq = 0;
    wr(5'h13, 0); wr(5'h14, 0); wr(5'h15, 0);
    @(negedge clk);
    chk(irq_n == 1, "R5 idle", irq_n, 1);

    // R10 forced test source persists
    wr(5'h12, 8'h01);
    @(negedge clk);
    chk(irq_n == 0, "R10 test asserts", irq_n, 0);
    repeat (5) @(negedge clk);
    chk_req("R10 held", 1, 0);
    rd(5'h12, d); chk(d == 8'h01, "R2 test readback", d, 1);
    wr(5'h12, 8'h00);
    @(negedge clk);
    chk(irq_n == 1, "R10 cleared", irq_n, 1);

    // R7 acknowledge mode off: status write ignored
    wr(5'h12, 8'h03);
    @(negedge clk);
    wr(5'h10, 8'h00);
    for (int k = 0; k < GAP + 2; k++) begin
      chk(irq_n == 0, "R7 line held", irq_n, 0);
      @(negedge clk);
    end
    chk_req("R7 req kept", 1, 1);

    // R8 acknowledge cycle
    wr(5'h11, 8'h01);
    @(negedge clk);
    chk(irq_n == 0, "R7 ackm write ignored", irq_n, 0);
    wr(5'h10, 8'h00);
    chk_req("R8 cleared", 0, 0);
    hi = 0;
    while (irq_n == 1 && hi < 50) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == GAP, "R8 gap length", hi, GAP);
    chk_req("R8 reasserted", 1, 1);
    rd(5'h11, d); chk(d == 8'h03, "R2 status readback", d, 3);

    // R11 write of 1 to request bit
    wr(5'h10, 8'h02);
    for (int k = 0; k < GAP + 1; k++) begin
      chk(irq_n == 0, "R11 no release", irq_n, 0);
      @(negedge clk);
    end

    // R9 acknowledge with nothing pending
    wr(5'h12, 8'h00);
    wr(5'h15, 8'h01);
    @(negedge clk);
    chk(irq_n == 1, "R9 idle before", irq_n, 1);
    wr(5'h11, 8'h01);
    uart_irq = 1;
    @(negedge clk);
    chk(irq_n == 0, "R9 no window", irq_n, 0);
    uart_irq = 0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule